// File: doc/BRIEF.md
# Three-Lane Linear-Phase FIR Filter with Fast-FIR Decomposition

This block filters a real-valued sample stream with a fixed 33-tap linear-phase impulse response while consuming three consecutive samples per clock. Each accepted block carries samples x(3k), x(3k+1) and x(3k+2) on lanes `x0`, `x1` and `x2`. One clock later the block returns the three matching filter outputs on `y0`, `y1` and `y2`. The stream is therefore processed at three times the clock rate without raising the clock.

Internally the coefficient set is split into three interleaved 11-tap phases. These are recombined into six 11-tap subfilters: phase 0, phase 1, phase0+phase2, phase0−phase2, phase1+phase2 and the sum of all three. The six subfilters run at the block rate and are fed by small pre-adders on the input lanes. Four of the six have mirrored or negated-mirrored tap sets, so their taps are folded in pairs and share one multiplier per pair. A post-combiner rebuilds the three outputs from the six subfilter results, using two one-block delays for the terms that cross a block boundary.

Coefficients are fixed at elaboration through a parameter that holds only the first half of the response. The mirror half is implied. The filter advances only on blocks marked valid.

Top module: `fir3p_symffa`

## Requirements
- R1: `out_valid` is high in the cycle after every clock edge at which `in_valid` was high, and low in the cycle after every edge at which `in_valid` was low.
- R2: For each accepted block k, the outputs are y(3k+j) = Σ_{m=0..32} h(m)·x(3k+j−m) for lane j. Samples before the first block after reset count as zero. Lane `x0` holds the oldest sample of a block and `x2` the newest.
- R3: The outputs are DW+CW+⌈log2 TAPS⌉ bits wide (38 by default). They are exact, with no wrap, for any mix of full-scale 16-bit inputs including −32768.
- R4: Parameter `HC` supplies h(0)..h(16). The block uses h(32−m) = h(m) for the upper half of the response.
- R5: While `in_valid` is low, the outputs hold their values and no filter state advances. A stream with idle gaps yields the same output sequence as the same stream without gaps.
- R6: Reset clears every delay element and the outputs to zero and drives `out_valid` low. After reset, the response starts from an all-zero history.
- R7: A single unit sample on `x0` followed by zero blocks reproduces h(0)..h(32) in order across the output lanes.
- R8: The sum and the difference of the phase0+phase2 and phase0−phase2 subfilter results are always even. Halving them by an arithmetic shift is therefore exact for all data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The three input lanes carry a block this cycle |
| x0 | input | 16 | Oldest sample of the block, signed |
| x1 | input | 16 | Middle sample of the block, signed |
| x2 | input | 16 | Newest sample of the block, signed |
| out_valid | output | 1 | The three output lanes carry a fresh result |
| y0 | output | 38 | Filter output for the oldest sample position, signed |
| y1 | output | 38 | Filter output for the middle sample position, signed |
| y2 | output | 38 | Filter output for the newest sample position, signed |

## Verification
The hardest situation to reach is one where the two block-boundary terms carry large values of opposite sign, while the recovered phase-2 product is near the limit of its width. An error in the shared-multiplier folding or in the halving then shows up only in a single lane, and only for a single block. The stimulus reaches it with full-scale runs of −32768 and alternating +32767/−32768 blocks, which drive every pre-adder to its extremes. Unit impulses on each lane in turn isolate the cross-block paths one at a time. Long random runs with random idle gaps then show that the delayed terms survive pauses.

// File: rtl/fir3p_pkg.sv
package fir3p_pkg;

  // Subfilter identities; the order is the index of each subfilter in the top.
  typedef enum logic [2:0] {
    SF_H0   = 3'd0,
    SF_H1   = 3'd1,
    SF_H02P = 3'd2,
    SF_H02M = 3'd3,
    SF_H12  = 3'd4,
    SF_H012 = 3'd5
  } sf_kind_e;

  // Tap-set symmetry of a subfilter.
  typedef enum logic [1:0] {
    SYM_NONE = 2'd0,
    SYM_EVEN = 2'd1,
    SYM_ODD  = 2'd2
  } sym_e;

  localparam int NSUB = 6;

endpackage

// File: rtl/fir3p_preadd.sv
module fir3p_preadd #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] x0,
  input  logic signed [DW-1:0] x1,
  input  logic signed [DW-1:0] x2,
  output logic signed [DW+1:0] u_h0,
  output logic signed [DW+1:0] u_h1,
  output logic signed [DW+1:0] u_h02p,
  output logic signed [DW+1:0] u_h02m,
  output logic signed [DW+1:0] u_h12,
  output logic signed [DW+1:0] u_h012
);
  localparam int UW = DW + 2;

  logic signed [UW-1:0] e0, e1, e2;

  always_comb begin
    e0     = UW'(x0);
    e1     = UW'(x1);
    e2     = UW'(x2);
    u_h0   = e0;
    u_h1   = e1;
    u_h02p = e0 + e2;
    u_h02m = e0 - e2;
    u_h12  = e1 + e2;
    u_h012 = e0 + e1 + e2;
  end

endmodule

// File: rtl/fir3p_subfilter.sv
module fir3p_subfilter
  import fir3p_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int TAPS = 33,
  parameter int HALF = 17,
  parameter int AW   = 42,
  parameter sf_kind_e KIND = SF_H0,
  parameter logic signed [CW-1:0] HC [HALF] = '{default: '0}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW+1:0] u,
  output logic signed [AW-1:0] acc
);
  localparam int UW  = DW + 2;
  localparam int L   = TAPS / 3;
  localparam int SCW = CW + 2;
  localparam int NP  = L / 2;
  localparam int MID = L / 2;

  // Full response, mirrored from the stored half.
  function automatic logic signed [SCW-1:0] hfull(input int k);
    if (k < HALF) return SCW'(HC[k]);
    else          return SCW'(HC[TAPS-1-k]);
  endfunction

  function automatic logic signed [SCW-1:0] coef(input int i);
    case (KIND)
      SF_H0:   return hfull(3*i);
      SF_H1:   return hfull(3*i+1);
      SF_H02P: return hfull(3*i) + hfull(3*i+2);
      SF_H02M: return hfull(3*i) - hfull(3*i+2);
      SF_H12:  return hfull(3*i+1) + hfull(3*i+2);
      default: return hfull(3*i) + hfull(3*i+1) + hfull(3*i+2);
    endcase
  endfunction

  localparam sym_e SYM = (KIND == SF_H1 || KIND == SF_H02P || KIND == SF_H012) ? SYM_EVEN :
                         (KIND == SF_H02M) ? SYM_ODD : SYM_NONE;
  localparam int NPROD = (SYM == SYM_NONE) ? L : ((SYM == SYM_EVEN) ? NP + 1 : NP);

  logic signed [UW-1:0] tap_q [L-1];
  logic signed [UW-1:0] tap_d [L-1];
  logic signed [UW-1:0] tap   [L];
  logic signed [AW-1:0] prod  [NPROD];

  // Delay line next state: shifts only on an accepted block.
  always_comb begin
    tap_d = tap_q;
    if (en) begin
      tap_d[0] = u;
      for (int i = 1; i < L - 1; i++) tap_d[i] = tap_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < L - 1; i++) tap_q[i] <= '0;
    end else begin
      tap_q <= tap_d;
    end
  end

  assign tap[0] = u;
  for (genvar g = 1; g < L; g++) begin : g_view
    assign tap[g] = tap_q[g-1];
  end

  if (SYM == SYM_NONE) begin : g_full
    for (genvar i = 0; i < L; i++) begin : g_t
      localparam logic signed [SCW-1:0] CI = coef(i);
      assign prod[i] = AW'(tap[i]) * AW'(CI);
    end
  end else begin : g_fold
    for (genvar i = 0; i < NP; i++) begin : g_t
      localparam logic signed [SCW-1:0] CI = coef(i);
      logic signed [UW:0] pre;
      assign pre = (SYM == SYM_EVEN) ? ((UW+1)'(tap[i]) + (UW+1)'(tap[L-1-i]))
                                     : ((UW+1)'(tap[i]) - (UW+1)'(tap[L-1-i]));
      assign prod[i] = AW'(pre) * AW'(CI);
    end
    if (SYM == SYM_EVEN) begin : g_mid
      localparam logic signed [SCW-1:0] CM = coef(MID);
      assign prod[NP] = AW'(tap[MID]) * AW'(CM);
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NPROD; i++) acc = acc + prod[i];
  end

  // R5: the delay line is frozen while no block is accepted.
  assert_line_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(tap_q[0]) && $stable(tap_q[L-2]));

endmodule

// File: rtl/fir3p_post.sv
module fir3p_post #(
  parameter int AW = 42,
  parameter int OW = 38
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [AW-1:0] p_h0,
  input  logic signed [AW-1:0] p_h1,
  input  logic signed [AW-1:0] p_h02p,
  input  logic signed [AW-1:0] p_h02m,
  input  logic signed [AW-1:0] p_h12,
  input  logic signed [AW-1:0] p_h012,
  output logic                 out_valid,
  output logic signed [OW-1:0] y0,
  output logic signed [OW-1:0] y1,
  output logic signed [OW-1:0] y2
);
  localparam int WW = AW + 2;

  logic signed [WW-1:0] w0, w1, wp, wm, w12, w012;
  logic signed [WW-1:0] dif2, sum2, cross02, ph2, cross12;
  logic signed [WW-1:0] y0_n, y1_n, y2_n;
  logic signed [WW-1:0] cross_q, cross_d, ph2_q, ph2_d;
  logic signed [OW-1:0] y0_d, y1_d, y2_d;
  logic                 ov_d;

  // Recombination of the six subfilter results.
  always_comb begin
    w0      = WW'(p_h0);
    w1      = WW'(p_h1);
    wp      = WW'(p_h02p);
    wm      = WW'(p_h02m);
    w12     = WW'(p_h12);
    w012    = WW'(p_h012);
    dif2    = wp - wm;
    sum2    = wp + wm;
    cross02 = dif2 >>> 1;
    ph2     = (sum2 >>> 1) - w0;
    cross12 = w12 - w1 - ph2;
    y0_n    = w0 + cross_q;
    y1_n    = w012 - w12 - w0 - cross02 + ph2_q;
    y2_n    = w1 + cross02;
  end

  // Next state for the block delays and the output stage.
  always_comb begin
    cross_d = cross_q;
    ph2_d   = ph2_q;
    y0_d    = y0;
    y1_d    = y1;
    y2_d    = y2;
    ov_d    = in_valid;
    if (in_valid) begin
      cross_d = cross12;
      ph2_d   = ph2;
      y0_d    = OW'(y0_n);
      y1_d    = OW'(y1_n);
      y2_d    = OW'(y2_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cross_q   <= '0;
      ph2_q     <= '0;
      y0        <= '0;
      y1        <= '0;
      y2        <= '0;
      out_valid <= 1'b0;
    end else begin
      cross_q   <= cross_d;
      ph2_q     <= ph2_d;
      y0        <= y0_d;
      y1        <= y1_d;
      y2        <= y2_d;
      out_valid <= ov_d;
    end
  end

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(y0) && $stable(y1) && $stable(y2));
  assert_half_exact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (!dif2[0] && !sum2[0]));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (((y0_n[WW-1:OW-1] == '0) || (y0_n[WW-1:OW-1] == '1)) &&
                  ((y1_n[WW-1:OW-1] == '0) || (y1_n[WW-1:OW-1] == '1)) &&
                  ((y2_n[WW-1:OW-1] == '0) || (y2_n[WW-1:OW-1] == '1))));

endmodule

// File: rtl/fir3p_symffa.sv
module fir3p_symffa
  import fir3p_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int TAPS = 33,
  parameter logic signed [CW-1:0] HC [(TAPS+1)/2] = '{
    16'sd1, 16'sd2, -16'sd3, 16'sd4, 16'sd5, -16'sd6, 16'sd7, 16'sd8, -16'sd9,
    16'sd10, 16'sd11, -16'sd12, 16'sd13, 16'sd14, -16'sd15, 16'sd16, 16'sd17}
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic signed [DW-1:0]             x0,
  input  logic signed [DW-1:0]             x1,
  input  logic signed [DW-1:0]             x2,
  output logic                             out_valid,
  output logic signed [DW+CW+$clog2(TAPS)-1:0] y0,
  output logic signed [DW+CW+$clog2(TAPS)-1:0] y1,
  output logic signed [DW+CW+$clog2(TAPS)-1:0] y2
);
  localparam int HALF = (TAPS + 1) / 2;
  localparam int UW   = DW + 2;
  localparam int AW   = DW + CW + 10;
  localparam int OW   = DW + CW + $clog2(TAPS);

  logic signed [UW-1:0] u_v [NSUB];
  logic signed [AW-1:0] a_v [NSUB];

  fir3p_preadd #(.DW(DW)) u_pre (
    .x0     (x0),
    .x1     (x1),
    .x2     (x2),
    .u_h0   (u_v[int'(SF_H0)]),
    .u_h1   (u_v[int'(SF_H1)]),
    .u_h02p (u_v[int'(SF_H02P)]),
    .u_h02m (u_v[int'(SF_H02M)]),
    .u_h12  (u_v[int'(SF_H12)]),
    .u_h012 (u_v[int'(SF_H012)])
  );

  for (genvar s = 0; s < NSUB; s++) begin : g_sf
    fir3p_subfilter #(
      .DW(DW), .CW(CW), .TAPS(TAPS), .HALF(HALF), .AW(AW),
      .KIND(sf_kind_e'(s)), .HC(HC)
    ) u_sf (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .u     (u_v[s]),
      .acc   (a_v[s])
    );
  end

  fir3p_post #(.AW(AW), .OW(OW)) u_post (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .p_h0      (a_v[int'(SF_H0)]),
    .p_h1      (a_v[int'(SF_H1)]),
    .p_h02p    (a_v[int'(SF_H02P)]),
    .p_h02m    (a_v[int'(SF_H02M)]),
    .p_h12     (a_v[int'(SF_H12)]),
    .p_h012    (a_v[int'(SF_H012)]),
    .out_valid (out_valid),
    .y0        (y0),
    .y1        (y1),
    .y2        (y2)
  );

endmodule

// File: tb/sim_fir3p_symffa.sv
`timescale 1ns/1ps
module sim_fir3p_symffa;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [15:0] x0, x1, x2;
  logic out_valid;
  logic signed [37:0] y0, y1, y2;

  int vectors = 0;
  int errors  = 0;
  int hist[$];
  longint exp_y [3];
  longint hc [33];

  always #5 clk = ~clk;

  fir3p_symffa u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x0(x0), .x1(x1), .x2(x2),
    .out_valid(out_valid), .y0(y0), .y1(y1), .y2(y2)
  );

  function automatic longint conv(input int n);
    longint s = 0;
    for (int m = 0; m < 33; m++)
      if (n - m >= 0) s += hc[m] * longint'(hist[n-m]);
    return s;
  endfunction

  task automatic check_out(input logic ev, input string tag);
    longint act [3];
    act[0] = longint'(y0); act[1] = longint'(y1); act[2] = longint'(y2);
    vectors++;
    if (out_valid !== ev) begin
      errors++;
      $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, ev);
    end
    for (int j = 0; j < 3; j++) begin
      vectors++;
      if (act[j] != exp_y[j]) begin
        errors++;
        $display("FAIL %s lane %0d actual %0d expected %0d", tag, j, act[j], exp_y[j]);
      end
    end
  endtask

  // Drive one cycle at a falling edge, then check at the next falling edge.
  task automatic step(input logic v, input int a, input int b, input int c, input string tag);
    in_valid = v; x0 = 16'(a); x1 = 16'(b); x2 = 16'(c);
    if (v) begin
      hist.push_back(a); hist.push_back(b); hist.push_back(c);
      for (int j = 0; j < 3; j++) exp_y[j] = conv(hist.size() - 3 + j);
    end
    @(negedge clk);
    check_out(v, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; x0 = '0; x1 = '0; x2 = '0;
    hist.delete();
    for (int j = 0; j < 3; j++) exp_y[j] = 0;
    repeat (3) @(negedge clk);
    check_out(1'b0, "R6");
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R4: mirrored response built from the same half values as the default.
    int half [17] = '{1, 2, -3, 4, 5, -6, 7, 8, -9, 10, 11, -12, 13, 14, -15, 16, 17};
    for (int m = 0; m < 17; m++) begin
      hc[m] = half[m];
      hc[32-m] = half[m];
    end

    do_reset();
    step(1'b0, 0, 0, 0, "R6");

    // R7: unit impulse on the oldest lane; later blocks show the mirror half (R4).
    step(1'b1, 1, 0, 0, "R7");
    for (int i = 0; i < 12; i++) step(1'b1, 0, 0, 0, (i >= 5) ? "R4" : "R7");
    // R2: impulses on the middle and newest lanes exercise the cross-block terms.
    step(1'b1, 0, 2, 0, "R2");
    for (int i = 0; i < 12; i++) step(1'b1, 0, 0, 0, "R2");
    step(1'b1, 0, 0, -3, "R2");
    for (int i = 0; i < 12; i++) step(1'b1, 0, 0, 0, "R2");
    // R2: step input.
    for (int i = 0; i < 14; i++) step(1'b1, 1000, 1000, 1000, "R2");
    // R3: full-scale negative run, then alternating extremes.
    for (int i = 0; i < 14; i++) step(1'b1, -32768, -32768, -32768, "R3");
    for (int i = 0; i < 20; i++)
      step(1'b1, (i % 2) ? 32767 : -32768, (i % 2) ? -32768 : 32767,
           (i % 3) ? 32767 : -32768, "R3");

    // R5 and R8: random data with random idle gaps.
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(3) == 0)
        step(1'b0, int'($urandom_range(65535)) - 32768, 7, -7, "R5");
      else
        step(1'b1, int'($urandom_range(65535)) - 32768,
             int'($urandom_range(65535)) - 32768,
             int'($urandom_range(65535)) - 32768, "R8");
    end

    // R6: reset in mid-stream clears history.
    do_reset();
    step(1'b1, 5, 0, 0, "R6");
    for (int i = 0; i < 12; i++) step(1'b1, 0, 0, 0, "R6");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule